// File: doc/BRIEF.md
# Resonant-Frequency Tracking Period Loop

This block keeps a resonant inverter switching at the resonance of its tank. Two 1-bit square waves arrive from external zero-crossing comparators: one follows the inverter voltage and one follows the capacitor voltage. Each is resynchronised to the system clock. The two are combined by an exclusive-OR phase detector. The fraction of each switching period during which they disagree is measured and normalised. That fraction is averaged by a first-order discrete low-pass filter. An integral controller then nudges the switching period until the averaged value sits at half scale, which is the 90-degree point. At that point the inverter voltage and the tank current are in phase and the switches commute at zero voltage.

A period counter produces the gate command and its complement as a square wave. The counter only advances on clock cycles where the sample strobe is high, so the strobe rate sets the time unit of every count. One control update runs for each completed switching period. Each update is a normalising division, then a filter step, then a period step, and a one-clock valid pulse marks its end. The filter coefficients, the integral gain and its ceiling, and the period limits are all inputs. Arithmetic uses 16 fractional bits. The minimum period must be at least 32 strobe cycles, so that an update finishes before the next period ends.

Top module: `rftrack_pll`

## Requirements
- R1: While the synchronous active-low reset is held, and up to the first update, period_o equals period_max_i, phase_o equals 32768 (half scale), gate_o is 0, gate_n_o is 1 and upd_o is 0. The integral gain resets to 1.
- R2: For an active period of P strobe cycles, gate_o is low for the first floor(P/2) strobe cycles and high for the remaining cycles. gate_n_o is always the inverse of gate_o.
- R3: upd_o is a single-clock pulse, issued once per completed switching period. While the period is unchanged, consecutive pulses are P strobe cycles apart.
- R4: On each update the filtered phase becomes x' = min(65536, floor((A·x + B·phi) / 65536)). A is coef_a_i and B is coef_b_i, both unsigned Q0.16. phi = floor(d·65536 / P), where d is the number of strobe cycles in the last period with the synchronised inputs unequal. phase_o changes only at the filter step, one clock before upd_o.
- R5: On each update the period becomes T' = clamp(T + floor(K·(x' − 32768) / 65536), period_min_i, period_max_i). K is the held gain and x' is the value just filtered. period_o changes only on the clock where upd_o is high.
- R6: A gain load (gain_ld_i high) with gain_i = 0 is ignored and the held gain is kept. A value above gain_lim_i is stored as gain_lim_i. Any other value is stored unchanged.
- R7: While smp_en_i is low, the period counter, the gate outputs and the duty count hold, and no update is started.
- R8: A new period value takes effect in the gate counter only at the end of a full switching period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en_i | input | 1 | Sample strobe; counters advance only when high |
| zc_inv_i | input | 1 | Square wave from the inverter-voltage comparator |
| zc_cap_i | input | 1 | Square wave from the capacitor-voltage comparator |
| coef_a_i | input | 16 | Filter feedback coefficient, unsigned Q0.16 |
| coef_b_i | input | 16 | Filter input coefficient, unsigned Q0.16 |
| gain_i | input | GW | Integral gain value to load, Q.16 |
| gain_ld_i | input | 1 | Load strobe for gain_i |
| gain_lim_i | input | GW | Stability ceiling for the gain |
| period_min_i | input | PW | Shortest allowed period, strobe cycles |
| period_max_i | input | PW | Longest allowed period and start period |
| gate_o | output | 1 | Gate command |
| gate_n_o | output | 1 | Complementary gate command |
| period_o | output | PW | Current period register |
| phase_o | output | 17 | Filtered phase, Q.16, half scale = 90 degrees |
| upd_o | output | 1 | One-clock pulse at the end of each control update |

## Verification
The bench goes after the rounding corners of the loop. Floor rounding on a negative error step is one such corner: a design that truncated toward zero would drift one count slow on every update. The clamp at both period limits is another: a design without it would wrap below the minimum or run past the maximum. Full-duty measurement, where phi is exactly 65536, is checked too, since an off-by-one in the divider or the duty counter would leave the filter short of full scale. Gain loads of zero and above the ceiling are checked through the next period steps, which would change size if the value were stored as given. A held strobe checks that neither the gate nor the update timer creeps forward. A fixed clamped period checks that gate high time and update spacing match the period exactly.

// File: rtl/rftrack_pkg.sv
package rftrack_pkg;
   localparam int FRAC = 16;
   localparam int ONE  = 1 << FRAC;
   localparam int HALF = 1 << (FRAC - 1);

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DIV,
      ST_FILT,
      ST_STEP
   } ctrl_st_e;
endpackage

// File: rtl/rft_sync.sv
module rft_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rft_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rft_timebase.sv
module rft_timebase #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          diff_i,
   input  logic [PW-1:0] per_new_i,
   input  logic [PW-1:0] per_rst_i,
   output logic          gate_o,
   output logic [PW-1:0] cnt_o,
   output logic [PW-1:0] per_act_o,
   output logic          wrap_o,
   output logic          meas_vld_o,
   output logic [PW-1:0] duty_o,
   output logic [PW-1:0] meas_per_o
);
   logic [PW-1:0] cnt_q, per_act_q, hi_q, duty_q, mper_q;
   logic          vld_q;

   assign wrap_o = en_i && ({1'b0, cnt_q} + 1'b1 >= {1'b0, per_act_q});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         per_act_q <= per_rst_i;
         hi_q      <= '0;
         duty_q    <= '0;
         mper_q    <= per_rst_i;
         vld_q     <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (wrap_o) begin
            cnt_q     <= '0;
            per_act_q <= per_new_i;
            duty_q    <= hi_q + PW'(diff_i);
            mper_q    <= per_act_q;
            hi_q      <= '0;
            vld_q     <= 1'b1;
         end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
            hi_q  <= hi_q + PW'(diff_i);
         end
      end
   end

   assign gate_o     = (cnt_q >= (per_act_q >> 1));
   assign cnt_o      = cnt_q;
   assign per_act_o  = per_act_q;
   assign meas_vld_o = vld_q;
   assign duty_o     = duty_q;
   assign meas_per_o = mper_q;
endmodule

// File: rtl/rft_ctrl.sv
module rft_ctrl
   import rftrack_pkg::*;
#(
   parameter int PW = 16,
   parameter int GW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [PW-1:0]   duty_i,
   input  logic [PW-1:0]   meas_per_i,
   input  logic [FRAC-1:0] coef_a_i,
   input  logic [FRAC-1:0] coef_b_i,
   input  logic [GW-1:0]   gain_i,
   input  logic            gain_ld_i,
   input  logic [GW-1:0]   gain_lim_i,
   input  logic [PW-1:0]   per_min_i,
   input  logic [PW-1:0]   per_max_i,
   output logic [FRAC:0]   phase_o,
   output logic [PW-1:0]   period_o,
   output logic            upd_o
);
   localparam int IW  = $clog2(FRAC + 2);
   localparam int MW  = 2 * FRAC + 2;
   localparam int EW  = FRAC + 2;
   localparam int PRW = GW + 1 + EW;

   ctrl_st_e       st_q;
   logic [PW:0]    rem_q;
   logic [PW-1:0]  div_q;
   logic [FRAC:0]  quo_q;
   logic [IW-1:0]  idx_q;
   logic [FRAC:0]  x_q;
   logic [PW-1:0]  per_q;
   logic [GW-1:0]  gain_q;
   logic           upd_q;

   // restoring division step: one quotient bit per clock
   logic           ge;
   logic [PW:0]    rem_nx;
   assign ge     = rem_q >= {1'b0, div_q};
   assign rem_nx = ge ? rem_q - {1'b0, div_q} : rem_q;

   // filter step
   logic [MW-1:0]     mix;
   logic [MW-FRAC-1:0] xsh;
   logic [FRAC:0]     x_nx;
   assign mix  = MW'(coef_a_i) * MW'(x_q) + MW'(coef_b_i) * MW'(quo_q);
   assign xsh  = mix[MW-1:FRAC];
   assign x_nx = (xsh > (MW-FRAC)'(ONE)) ? (FRAC+1)'(ONE) : xsh[FRAC:0];

   // period step
   logic signed [EW-1:0]  err;
   logic signed [PRW-1:0] prod, step, sum, lo, hi;
   logic [PW-1:0]         per_nx;
   assign err    = $signed({1'b0, x_q}) - $signed(EW'(HALF));
   assign prod   = PRW'($signed({1'b0, gain_q})) * PRW'(err);
   assign step   = prod >>> FRAC;
   assign sum    = PRW'($signed({1'b0, per_q})) + step;
   assign lo     = PRW'($signed({1'b0, per_min_i}));
   assign hi     = PRW'($signed({1'b0, per_max_i}));
   assign per_nx = (sum < lo) ? per_min_i : (sum > hi) ? per_max_i : sum[PW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_q <= GW'(1);
      end else if (gain_ld_i && gain_i != '0) begin
         gain_q <= (gain_i > gain_lim_i) ? gain_lim_i : gain_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         rem_q <= '0;
         div_q <= '0;
         quo_q <= '0;
         idx_q <= '0;
         x_q   <= (FRAC+1)'(HALF);
         per_q <= per_max_i;
         upd_q <= 1'b0;
      end else begin
         upd_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               rem_q <= {1'b0, duty_i};
               div_q <= meas_per_i;
               quo_q <= '0;
               idx_q <= '0;
               st_q  <= ST_DIV;
            end
            ST_DIV: begin
               quo_q <= {quo_q[FRAC-1:0], ge};
               rem_q <= {rem_nx[PW-1:0], 1'b0};
               idx_q <= idx_q + 1'b1;
               if (idx_q == IW'(FRAC)) st_q <= ST_FILT;
            end
            ST_FILT: begin
               x_q  <= x_nx;
               st_q <= ST_STEP;
            end
            ST_STEP: begin
               per_q <= per_nx;
               upd_q <= 1'b1;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign phase_o  = x_q;
   assign period_o = per_q;
   assign upd_o    = upd_q;
endmodule

// File: rtl/rftrack_pll.sv
module rftrack_pll
   import rftrack_pkg::*;
#(
   parameter int PW          = 16,
   parameter int GW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_en_i,
   input  logic          zc_inv_i,
   input  logic          zc_cap_i,
   input  logic [15:0]   coef_a_i,
   input  logic [15:0]   coef_b_i,
   input  logic [GW-1:0] gain_i,
   input  logic          gain_ld_i,
   input  logic [GW-1:0] gain_lim_i,
   input  logic [PW-1:0] period_min_i,
   input  logic [PW-1:0] period_max_i,
   output logic          gate_o,
   output logic          gate_n_o,
   output logic [PW-1:0] period_o,
   output logic [16:0]   phase_o,
   output logic          upd_o
);
   if (PW < 8 || PW > 24) begin : g_bad_pw
      $error("rftrack_pll: PW must lie in 8..24");
   end
   if (GW < 1 || GW > 24) begin : g_bad_gw
      $error("rftrack_pll: GW must lie in 1..24");
   end
   if (FRAC != 16) begin : g_bad_frac
      $error("rftrack_pll: ports assume 16 fractional bits");
   end

   logic [1:0]    zc_s;
   logic          diff;
   logic          gate_w, wrap_w, meas_vld;
   logic [PW-1:0] cnt_w, per_act_w, duty_w, mper_w, per_q_w;

   rft_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({zc_inv_i, zc_cap_i}),
      .q_o   (zc_s)
   );

   assign diff = zc_s[1] ^ zc_s[0];

   rft_timebase #(.PW(PW)) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (smp_en_i),
      .diff_i     (diff),
      .per_new_i  (per_q_w),
      .per_rst_i  (period_max_i),
      .gate_o     (gate_w),
      .cnt_o      (cnt_w),
      .per_act_o  (per_act_w),
      .wrap_o     (wrap_w),
      .meas_vld_o (meas_vld),
      .duty_o     (duty_w),
      .meas_per_o (mper_w)
   );

   rft_ctrl #(.PW(PW), .GW(GW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (meas_vld),
      .duty_i     (duty_w),
      .meas_per_i (mper_w),
      .coef_a_i   (coef_a_i),
      .coef_b_i   (coef_b_i),
      .gain_i     (gain_i),
      .gain_ld_i  (gain_ld_i),
      .gain_lim_i (gain_lim_i),
      .per_min_i  (period_min_i),
      .per_max_i  (period_max_i),
      .phase_o    (phase_o),
      .period_o   (per_q_w),
      .upd_o      (upd_o)
   );

   assign period_o = per_q_w;
   assign gate_o   = gate_w;
   assign gate_n_o = ~gate_w;
endmodule

// File: rtl/rftrack_pll_chk.sv
module rftrack_pll_chk #(
   parameter int PW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_en_i,
   input logic          gate_o,
   input logic          upd_o,
   input logic [16:0]   phase_o,
   input logic [PW-1:0] period_o,
   input logic [PW-1:0] period_min_i,
   input logic [PW-1:0] period_max_i,
   input logic [PW-1:0] cnt_w,
   input logic [PW-1:0] per_act_w,
   input logic          wrap_w
);
   AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o); // R3

   AST_PHASE_BEFORE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_o) |-> upd_o == 1'b0 ##1 upd_o); // R4

   AST_PERIOD_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(period_o) |-> upd_o); // R5

   AST_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> (period_o >= period_min_i && period_o <= period_max_i)); // R5

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en_i |=> ($stable(cnt_w) && $stable(gate_o))); // R7

   AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_w |=> $stable(per_act_w)); // R8
endmodule

bind rftrack_pll rftrack_pll_chk #(.PW(PW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .smp_en_i     (smp_en_i),
   .gate_o       (gate_o),
   .upd_o        (upd_o),
   .phase_o      (phase_o),
   .period_o     (period_o),
   .period_min_i (period_min_i),
   .period_max_i (period_max_i),
   .cnt_w        (cnt_w),
   .per_act_w    (per_act_w),
   .wrap_w       (wrap_w)
);

// File: tb/rftrack_pll_tb.sv
module rftrack_pll_tb;
   localparam int PW = 16;
   localparam int GW = 16;
   localparam int PMIN = 40;
   localparam int PMAX = 200;

   typedef struct packed {
      logic [15:0] a;
      logic [15:0] b;
      logic [15:0] kc;
      logic [15:0] lim;
      logic        lvl;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{a:16'd49152, b:16'd16384, kc:16'd16,    lim:16'd1000,  lvl:1'b0},
      '{a:16'd49152, b:16'd16384, kc:16'd0,     lim:16'd1000,  lvl:1'b1},
      '{a:16'd49152, b:16'd16384, kc:16'd60000, lim:16'd32,    lvl:1'b0},
      '{a:16'd0,     b:16'd65535, kc:16'd65535, lim:16'd65535, lvl:1'b0},
      '{a:16'd32768, b:16'd32768, kc:16'd65535, lim:16'd65535, lvl:1'b1},
      '{a:16'd65535, b:16'd1,     kc:16'd8,     lim:16'd65535, lvl:1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_en_i = 1'b1;
   logic          zc_inv_i = 1'b0, zc_cap_i = 1'b0;
   logic [15:0]   coef_a_i = 16'd49152, coef_b_i = 16'd16384;
   logic [GW-1:0] gain_i = '0, gain_lim_i = 16'd65535;
   logic          gain_ld_i = 1'b0;
   logic [PW-1:0] period_min_i = PW'(PMIN), period_max_i = PW'(PMAX);
   logic          gate_o, gate_n_o, upd_o;
   logic [PW-1:0] period_o;
   logic [16:0]   phase_o;

   int total = 0, bad = 0;
   longint cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rftrack_pll #(.PW(PW), .GW(GW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en_i),
      .zc_inv_i(zc_inv_i), .zc_cap_i(zc_cap_i),
      .coef_a_i(coef_a_i), .coef_b_i(coef_b_i),
      .gain_i(gain_i), .gain_ld_i(gain_ld_i), .gain_lim_i(gain_lim_i),
      .period_min_i(period_min_i), .period_max_i(period_max_i),
      .gate_o(gate_o), .gate_n_o(gate_n_o), .period_o(period_o),
      .phase_o(phase_o), .upd_o(upd_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint m_x(longint a, longint b, longint x, bit lvl);
      longint v;
      v = (a * x + b * (lvl ? 65536 : 0)) >>> 16;
      return (v > 65536) ? 65536 : v;
   endfunction

   function automatic longint m_t(longint t, longint kc, longint xn);
      longint v;
      v = t + ((kc * (xn - 32768)) >>> 16);
      if (v < PMIN) v = PMIN;
      if (v > PMAX) v = PMAX;
      return v;
   endfunction

   task automatic wait_upd(output longint at);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!upd_o && n < 5000);
      at = cyc;
      if (!upd_o) chk(1'b0, "R3 update timeout", 0, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      longint kc_m = 1, xp, tp, tpp, xn, tn, at, at_prev;
      int hi_cnt, mis, ups;
      logic g0;

      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(period_o == PW'(PMAX), "R1 period reset", period_o, PMAX);
      chk(phase_o == 17'd32768, "R1 phase reset", phase_o, 32768);
      chk(gate_o == 1'b0 && gate_n_o == 1'b1, "R1 gate reset", gate_o, 0);
      chk(upd_o == 1'b0, "R1 upd reset", upd_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(period_o == PW'(PMAX) && phase_o == 17'd32768, "R1 after release", period_o, PMAX);

      // table walk: R4 filter, R5 period step, R6 gain load, R3 spacing
      for (int r = 0; r < NV; r++) begin
         wait_upd(at);
         coef_a_i   = VEC[r].a;
         coef_b_i   = VEC[r].b;
         gain_lim_i = VEC[r].lim;
         gain_i     = VEC[r].kc;
         zc_inv_i   = VEC[r].lvl;
         gain_ld_i  = 1'b1;
         @(negedge clk);
         gain_ld_i  = 1'b0;
         if (VEC[r].kc != 0) kc_m = (VEC[r].kc > VEC[r].lim) ? VEC[r].lim : VEC[r].kc;
         wait_upd(at);
         wait_upd(at);
         xp = phase_o; tp = period_o; tpp = -1; at_prev = at;
         for (int k = 0; k < 6; k++) begin
            wait_upd(at);
            xn = m_x(VEC[r].a, VEC[r].b, xp, VEC[r].lvl);
            tn = m_t(tp, kc_m, xn);
            chk(phase_o == 17'(xn), $sformatf("R4 filter row %0d", r), phase_o, xn);
            chk(period_o == PW'(tn), $sformatf("R5 period row %0d (R6 gain %0d)", r, kc_m),
                period_o, tn);
            if (tpp == tp && tp == longint'(period_o))
               chk(at - at_prev == tp, "R3 update spacing", at - at_prev, tp);
            tpp = tp; xp = phase_o; tp = period_o; at_prev = at;
         end
      end

      // R2: drive to minimum period and measure the gate
      coef_a_i = 16'd0; coef_b_i = 16'd65535; zc_inv_i = 1'b0;
      gain_lim_i = 16'd65535; gain_i = 16'd65535; gain_ld_i = 1'b1;
      @(negedge clk); gain_ld_i = 1'b0;
      repeat (4) wait_upd(at);
      chk(period_o == PW'(PMIN), "R5 clamp at minimum", period_o, PMIN);
      hi_cnt = 0; mis = 0;
      for (int i = 0; i < 3 * PMIN; i++) begin
         @(negedge clk);
         if (gate_o) hi_cnt++;
         if (gate_n_o !== ~gate_o) mis++;
      end
      chk(hi_cnt == 3 * (PMIN - PMIN / 2), "R2 gate high time", hi_cnt, 3 * (PMIN - PMIN / 2));
      chk(mis == 0, "R2 complementary output", mis, 0);

      // R7: strobe held low
      @(negedge clk);
      smp_en_i = 1'b0;
      repeat (40) @(negedge clk);
      g0 = gate_o; mis = 0; ups = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (gate_o !== g0) mis++;
         if (upd_o) ups++;
      end
      chk(mis == 0, "R7 gate frozen", mis, 0);
      chk(ups == 0, "R7 no update", ups, 0);
      smp_en_i = 1'b1;
      wait_upd(at);
      chk(upd_o == 1'b1, "R7 resumes", upd_o, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule